// File: doc/BRIEF.md
# Ping-Pong Dual-Clock Frame Buffer

This block stores two complete screens of pixel words in one inferred dual-port RAM. The top address bit divides the RAM into two equal banks. A slow parallel writer fills one bank on its own clock while a fast display scanner reads the other bank on a separate clock. Neither side ever waits for the other.

The writer gives only the word offset inside a bank, and the block adds the writer's current bank bit to it. The scanner also gives only an offset and receives data from the opposite bank. When the writer has stored the last word of a frame, it pulses `wr_frame_done`. The swap request crosses into the read domain through a two-flop synchronizer. The scanner's bank changes only when it marks a frame boundary with `rd_frame_start`. The acknowledge then crosses back to the write domain, and only then does the writer move to the bank the scanner has just released.

While a swap is pending, the writer's writes are discarded. This keeps the two sides on opposite halves at all times. A second `wr_frame_done` that arrives while a swap is still pending sets a sticky overrun flag and does not queue another swap.

Top module: `pingpong_fb`

## Requirements
- R1: After reset, `wr_bank` is 0 (bank A), `rd_bank` is 1 (bank B), and `wr_swap_pending` and `wr_overrun` are both 0.
- R2: A write with `wr_en` high and no pending swap stores `wr_data` at RAM word {`wr_bank`, `wr_addr`}. Once the banks have swapped, the reader sees that word at the same offset.
- R3: `rd_data` is registered on `rd_clk`. It presents the word at {`rd_bank`, `rd_addr`} after the first rising `rd_clk` edge that follows a change of `rd_addr`, and it holds its value between edges.
- R4: A `wr_frame_done` pulse with no swap pending raises `wr_swap_pending` after the next `wr_clk` edge. `rd_bank` does not change until `rd_frame_start` is seen.
- R5: While a request is pending, `rd_frame_start` inverts `rd_bank`. After the acknowledge returns, `wr_bank` inverts and `wr_swap_pending` clears.
- R6: `rd_frame_start` with no request pending leaves `rd_bank` and `wr_bank` unchanged.
- R7: Writes made while `wr_swap_pending` is 1 are discarded. The addressed word keeps its earlier value.
- R8: `wr_frame_done` while a swap is pending sets `wr_overrun`. The flag stays set until reset, and only one swap results.
- R9: Writes to the writer's bank are not visible to the reader, which keeps reading the other bank at the same offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Writer clock |
| wr_rst_n | input | 1 | Writer-domain asynchronous reset, active low |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | AW-1 | Word offset inside the writer's bank |
| wr_data | input | DW | Word to store |
| wr_frame_done | input | 1 | One-cycle pulse after the last word of a frame |
| wr_bank | output | 1 | Bank the writer currently owns |
| wr_swap_pending | output | 1 | Swap requested and not yet acknowledged |
| wr_overrun | output | 1 | Sticky flag: frame completed while a swap was pending |
| rd_clk | input | 1 | Scanner clock |
| rd_rst_n | input | 1 | Reader-domain asynchronous reset, active low |
| rd_frame_start | input | 1 | Scanner frame-boundary pulse |
| rd_addr | input | AW-1 | Word offset inside the reader's bank |
| rd_data | output | DW | Registered read word |
| rd_bank | output | 1 | Bank the reader currently owns |

## Verification
The bench builds the block with DW=16 and AW=6, so each bank holds 32 words. With banks this small, the first and last offsets of a bank can be written and read back in a few cycles. The small size also lets the bench run several full swap cycles, including dropped writes and an overrun, in one short run. The two clocks have unrelated periods (10 ns and 6 ns), so the synchronizer latency in each direction is exercised rather than assumed.

// File: rtl/pingpong_fb.sv
module pingpong_fb #(
  parameter int DW = 16,
  parameter int AW = 12
) (
  input  logic          wr_clk,
  input  logic          wr_rst_n,
  input  logic          wr_en,
  input  logic [AW-2:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          wr_frame_done,
  output logic          wr_bank,
  output logic          wr_swap_pending,
  output logic          wr_overrun,
  input  logic          rd_clk,
  input  logic          rd_rst_n,
  input  logic          rd_frame_start,
  input  logic [AW-2:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic          rd_bank
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  logic req_q, ack_s1, ack_s2, ovr_q;
  logic req_s1, req_s2, ack_q;
  logic rd_pend;

  assign wr_bank         = ack_s2;
  assign wr_swap_pending = req_q ^ ack_s2;
  assign wr_overrun      = ovr_q;
  assign rd_bank         = ~ack_q;
  assign rd_pend         = req_s2 ^ ack_q;

  always_ff @(posedge wr_clk or negedge wr_rst_n)
    if (!wr_rst_n) begin
      req_q  <= 1'b0;
      ack_s1 <= 1'b0;
      ack_s2 <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      ack_s1 <= ack_q;
      ack_s2 <= ack_s1;
      if (wr_frame_done) begin
        if (wr_swap_pending) ovr_q <= 1'b1;
        else                 req_q <= ~req_q;
      end
    end

  always_ff @(posedge wr_clk)
    if (wr_en && !wr_swap_pending)
      mem[{wr_bank, wr_addr}] <= wr_data;

  always_ff @(posedge rd_clk or negedge rd_rst_n)
    if (!rd_rst_n) begin
      req_s1 <= 1'b0;
      req_s2 <= 1'b0;
      ack_q  <= 1'b0;
    end else begin
      req_s1 <= req_q;
      req_s2 <= req_s1;
      if (rd_frame_start && rd_pend) ack_q <= req_s2;
    end

  always_ff @(posedge rd_clk)
    rd_data <= mem[{rd_bank, rd_addr}];

  a_r4_rd_bank_hold: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    !rd_frame_start |=> $stable(rd_bank));

  a_r5_rd_flip_on_boundary: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    !$stable(rd_bank) |-> $past(rd_frame_start));

  a_r5_wr_flip_only_pending: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    !$stable(wr_bank) |-> $past(wr_swap_pending));

  a_r8_overrun_sticky: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    wr_overrun |=> wr_overrun);

  a_r8_overrun_cause: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    $rose(wr_overrun) |-> $past(wr_frame_done && wr_swap_pending));
endmodule

// File: tb/test_pingpong_fb.sv
module test_pingpong_fb;
  localparam int DW = 16;
  localparam int AW = 6;
  localparam int NV = 8;
  localparam logic [AW-2+DW:0] VEC [NV] = '{
    {5'd0,  16'hA001}, {5'd31, 16'hA01F}, {5'd1,  16'h5555}, {5'd30, 16'hAAAA},
    {5'd7,  16'h0000}, {5'd16, 16'hFFFF}, {5'd3,  16'h1234}, {5'd12, 16'hC0DE}
  };

  logic wr_clk = 0, rd_clk = 0;
  logic wr_rst_n = 0, rd_rst_n = 0;
  logic wr_en = 0, wr_frame_done = 0, rd_frame_start = 0;
  logic [AW-2:0] wr_addr = '0, rd_addr = '0;
  logic [DW-1:0] wr_data = '0, rd_data;
  logic wr_bank, wr_swap_pending, wr_overrun, rd_bank;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 wr_clk = ~wr_clk;
  always #3 rd_clk = ~rd_clk;

  pingpong_fb #(.DW(DW), .AW(AW)) i_pingpong_fb (
    .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_frame_done(wr_frame_done), .wr_bank(wr_bank),
    .wr_swap_pending(wr_swap_pending), .wr_overrun(wr_overrun),
    .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .rd_frame_start(rd_frame_start),
    .rd_addr(rd_addr), .rd_data(rd_data), .rd_bank(rd_bank));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_word(input logic [AW-2:0] a, input logic [DW-1:0] d);
    @(negedge wr_clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge wr_clk); wr_en = 0;
  endtask

  task automatic rd_word(input logic [AW-2:0] a, output logic [DW-1:0] d);
    @(negedge rd_clk); rd_addr = a;
    @(negedge rd_clk); d = rd_data;
  endtask

  task automatic frame_done();
    @(negedge wr_clk); wr_frame_done = 1;
    @(negedge wr_clk); wr_frame_done = 0;
  endtask

  task automatic frame_start();
    @(negedge rd_clk); rd_frame_start = 1;
    @(negedge rd_clk); rd_frame_start = 0;
  endtask

  task automatic settle();
    repeat (6) @(negedge wr_clk);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    logic [DW-1:0] d;
    repeat (3) @(negedge wr_clk);
    wr_rst_n = 1; rd_rst_n = 1;
    @(negedge wr_clk);
    chk("R1 wr_bank", wr_bank, 0);
    chk("R1 rd_bank", rd_bank, 1);
    chk("R1 pending", wr_swap_pending, 0);
    chk("R1 overrun", wr_overrun, 0);

    for (int i = 0; i < NV; i++) wr_word(VEC[i][AW-2+DW:DW], VEC[i][DW-1:0]);
    frame_done();
    settle();
    chk("R4 pending raised", wr_swap_pending, 1);
    chk("R4 rd_bank held", rd_bank, 1);
    chk("R4 wr_bank held", wr_bank, 0);
    frame_start();
    settle();
    chk("R5 rd_bank flipped", rd_bank, 0);
    chk("R5 wr_bank flipped", wr_bank, 1);
    chk("R5 pending cleared", wr_swap_pending, 0);
    for (int i = 0; i < NV; i++) begin
      rd_word(VEC[i][AW-2+DW:DW], d);
      chk("R2 readback", d, VEC[i][DW-1:0]);
    end

    rd_word(5'd0, d);
    @(negedge rd_clk); rd_addr = 5'd31;
    #1 chk("R3 held between edges", rd_data, 16'hA001);
    @(negedge rd_clk);
    chk("R3 updated after edge", rd_data, 16'hA01F);

    wr_word(5'd0, 16'hBEEF);
    wr_word(5'd3, 16'h7777);
    rd_word(5'd0, d);
    chk("R9 reader isolated", d, 16'hA001);

    frame_start();
    settle();
    chk("R6 rd_bank unchanged", rd_bank, 0);
    chk("R6 wr_bank unchanged", wr_bank, 1);

    frame_done();
    settle();
    chk("R7 pending", wr_swap_pending, 1);
    wr_word(5'd3, 16'hDEAD);
    frame_start();
    settle();
    chk("R5 second swap rd_bank", rd_bank, 1);
    chk("R5 second swap wr_bank", wr_bank, 0);
    rd_word(5'd3, d);
    chk("R7 pending write dropped", d, 16'h7777);
    rd_word(5'd0, d);
    chk("R2 bank B readback", d, 16'hBEEF);
    chk("R8 no overrun yet", wr_overrun, 0);

    frame_done();
    frame_done();
    settle();
    chk("R8 overrun set", wr_overrun, 1);
    frame_start();
    settle();
    chk("R8 single swap rd_bank", rd_bank, 0);
    chk("R8 pending cleared", wr_swap_pending, 0);
    frame_start();
    settle();
    chk("R8 no second swap", rd_bank, 0);
    chk("R8 overrun sticky", wr_overrun, 1);

    done = 1;
    summary();
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end
endmodule